// File: doc/BRIEF.md
# Load/Store RISC Instruction Decoder

This block turns one 32-bit instruction word of a small load/store RISC subset into the control bundle that a single-cycle datapath needs. The instruction comes from the fetch stage and the control signals leave it in the same cycle. There is no register, no clock and no flow control. The decoder pulls out the register indices and works out which register is written. It picks the ALU operation and whether the second ALU operand is the immediate. It then extends the 16-bit immediate by the rule for that instruction and raises the memory, branch, jump and link flags.

Three layouts share the word. In every layout the opcode sits in the six most significant bits. The register form has two source indices, a destination index, a shift amount and a six-bit function code. The immediate form has two indices and a 16-bit constant, and its destination is the second index. The jump form carries a 26-bit target. Thirteen operations are recognised: three register-form arithmetic operations, a register-indirect jump, three immediate arithmetic forms, a word load and a word store, two compare-and-branch operations, a plain jump and a jump that links. Any other word raises an illegal flag and disables every side effect.

The register file, the ALU, the memories and the next-PC adder sit around the block. The decoder only tells them what to do.

Top module: `mdec_top`

## Requirements
- R1: `rs_idx_o` always equals instruction bits [25:21], `rt_idx_o` equals bits [20:16] and `jtarget_o` equals bits [25:0], whatever the opcode.
- R2: With opcode 000000 and shift field [10:6] zero, function 100000 gives ALU code 0 (add), 100010 gives code 1 (sub) and 101010 gives code 2 (signed set-less-than). All three select the register operand (`alu_src_imm_o`=0), take the destination from bits [15:11] and request a write.
- R3: Opcode 001000 (add immediate) gives ALU code 0, opcode 001101 (or immediate) gives code 3 and opcode 001111 (load upper) gives code 4 (pass operand B). All three select the immediate operand, take the destination from bits [20:16] and request a write.
- R4: The extension mode is 1 (zero) for or-immediate and 2 (upper) for load-upper. Every other word gets mode 0 (sign). `imm_o` is bits [15:0] sign-extended in mode 0 and zero-extended in mode 1. In mode 2 the same bits are placed in [31:16] with the low half zero.
- R5: Opcode 100011 (load word) sets `mem_rd_o`, ALU code 0, the immediate operand and a write to bits [20:16]. Opcode 101011 (store word) sets `mem_wr_o`, ALU code 0 and the immediate operand, and it writes no register.
- R6: Opcode 000100 (branch if equal) and opcode 000101 (branch if not equal) set `branch_o` and ALU code 1 and write no register. `branch_ne_o` is 1 only for 000101.
- R7: Opcode 000010 sets `jump_o` and writes nothing. Opcode 000011 sets `jump_o` and `link_o` and writes register 31 (`wr_idx_o`=31, `reg_we_o`=1).
- R8: Opcode 000000 with function 001000 sets `jump_reg_o`. It writes no register and touches no memory, whatever the values in bits [20:6].
- R9: `wr_idx_o` is bits [15:11] for opcode 000000, 31 for opcode 000011 and bits [20:16] otherwise. `reg_we_o` is 0 whenever that index is 0.
- R10: Any opcode outside the subset raises `illegal_o`, and so does a register-form function outside the subset or a register-form arithmetic word with a nonzero shift field. When it is raised, `reg_we_o`, `mem_rd_o`, `mem_wr_o`, `branch_o`, `branch_ne_o`, `jump_o`, `jump_reg_o`, `link_o` and `alu_src_imm_o` are 0, and the ALU and extension codes are 0.
- R11: At most one of `mem_rd_o`, `mem_wr_o`, `branch_o`, `jump_o` and `jump_reg_o` is 1 for any word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| instr_i | input | 32 | Instruction word to decode |
| rs_idx_o | output | 5 | First source register index |
| rt_idx_o | output | 5 | Second source register index |
| wr_idx_o | output | 5 | Destination register index |
| reg_we_o | output | 1 | Register file write enable |
| alu_op_o | output | 3 | ALU code: 0 add, 1 sub, 2 slt, 3 or, 4 pass B |
| alu_src_imm_o | output | 1 | ALU operand B is the immediate |
| ext_mode_o | output | 2 | Immediate rule: 0 sign, 1 zero, 2 upper |
| imm_o | output | 32 | Extended immediate |
| mem_rd_o | output | 1 | Data memory read |
| mem_wr_o | output | 1 | Data memory write |
| branch_o | output | 1 | Conditional branch |
| branch_ne_o | output | 1 | Branch taken on inequality |
| jump_o | output | 1 | Direct jump |
| jump_reg_o | output | 1 | Jump to the address in the first source register |
| link_o | output | 1 | Save the return address in register 31 |
| jtarget_o | output | 26 | Direct jump target field |
| illegal_o | output | 1 | Word is outside the subset |

## Verification
The assertions are immediate checks that are evaluated only while the instruction word carries no unknown bits. They take it for granted that the fetch stage supplies a word that is fully defined. The bench drives a defined word from the first clock on. It changes that word only just after a rising edge and compares on the falling edge, once the combinational outputs have settled. The stimulus covers the thirteen legal forms with both zero and nonzero destinations and with negative, positive and 0x8000 immediates. It adds illegal opcodes, unsupported functions and nonzero shift fields, plus a few hundred words that are either random or built from random legal opcodes.

// File: rtl/mdec_pkg.sv
package mdec_pkg;
  localparam int XLEN     = 32;
  localparam int OP_W     = 6;
  localparam int FN_W     = 6;
  localparam int RIDX_W   = 5;
  localparam int SH_W     = 5;
  localparam int IMM_W    = 16;
  localparam int JT_W     = 26;
  localparam int LINK_IDX = 31;

  localparam logic [OP_W-1:0] OPC_REG   = 6'b000000;
  localparam logic [OP_W-1:0] OPC_JMP   = 6'b000010;
  localparam logic [OP_W-1:0] OPC_JLINK = 6'b000011;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'b000100;
  localparam logic [OP_W-1:0] OPC_BNE   = 6'b000101;
  localparam logic [OP_W-1:0] OPC_ADDI  = 6'b001000;
  localparam logic [OP_W-1:0] OPC_ORI   = 6'b001101;
  localparam logic [OP_W-1:0] OPC_LUI   = 6'b001111;
  localparam logic [OP_W-1:0] OPC_LDW   = 6'b100011;
  localparam logic [OP_W-1:0] OPC_STW   = 6'b101011;

  localparam logic [FN_W-1:0] FN_ADD = 6'b100000;
  localparam logic [FN_W-1:0] FN_SUB = 6'b100010;
  localparam logic [FN_W-1:0] FN_SLT = 6'b101010;
  localparam logic [FN_W-1:0] FN_JRG = 6'b001000;

  typedef enum logic [2:0] {
    ALU_ADD   = 3'd0,
    ALU_SUB   = 3'd1,
    ALU_SLT   = 3'd2,
    ALU_OR    = 3'd3,
    ALU_PASSB = 3'd4
  } alu_op_e;

  typedef enum logic [1:0] {
    EXT_SIGN  = 2'd0,
    EXT_ZERO  = 2'd1,
    EXT_UPPER = 2'd2
  } ext_e;

  typedef enum logic [1:0] {
    DST_RD   = 2'd0,
    DST_RT   = 2'd1,
    DST_LINK = 2'd2
  } dst_e;

  typedef struct packed {
    logic    wants_wr;
    dst_e    dst;
    alu_op_e alu;
    logic    src_imm;
    ext_e    ext;
    logic    mrd;
    logic    mwr;
    logic    br;
    logic    br_ne;
    logic    jmp;
    logic    jreg;
    logic    link;
    logic    illegal;
  } ctrl_t;
endpackage

// File: rtl/mdec_fields.sv
module mdec_fields
  import mdec_pkg::*;
(
  input  logic [XLEN-1:0]   instr,
  output logic [OP_W-1:0]   op,
  output logic [RIDX_W-1:0] rs,
  output logic [RIDX_W-1:0] rt,
  output logic [RIDX_W-1:0] rd,
  output logic [SH_W-1:0]   shamt,
  output logic [FN_W-1:0]   funct,
  output logic [IMM_W-1:0]  imm,
  output logic [JT_W-1:0]   jt
);
  localparam int OP_LSB = XLEN - OP_W;
  localparam int RS_LSB = OP_LSB - RIDX_W;
  localparam int RT_LSB = RS_LSB - RIDX_W;
  localparam int RD_LSB = RT_LSB - RIDX_W;
  localparam int SH_LSB = RD_LSB - SH_W;

  assign op    = instr[OP_LSB +: OP_W];
  assign rs    = instr[RS_LSB +: RIDX_W];
  assign rt    = instr[RT_LSB +: RIDX_W];
  assign rd    = instr[RD_LSB +: RIDX_W];
  assign shamt = instr[SH_LSB +: SH_W];
  assign funct = instr[0 +: FN_W];
  assign imm   = instr[0 +: IMM_W];
  assign jt    = instr[0 +: JT_W];
endmodule

// File: rtl/mdec_ctrl.sv
module mdec_ctrl
  import mdec_pkg::*;
(
  input  logic [OP_W-1:0] op,
  input  logic [FN_W-1:0] funct,
  input  logic [SH_W-1:0] shamt,
  output ctrl_t           ctrl
);
  logic shamt_zero;
  assign shamt_zero = (shamt == '0);

  always_comb begin
    ctrl          = '0;
    ctrl.dst      = (op == OPC_REG) ? DST_RD : DST_RT;
    ctrl.alu      = ALU_ADD;
    ctrl.ext      = EXT_SIGN;
    unique case (op)
      OPC_REG: begin
        unique case (funct)
          FN_ADD: begin
            ctrl.wants_wr = shamt_zero;
            ctrl.illegal  = !shamt_zero;
          end
          FN_SUB: begin
            ctrl.wants_wr = shamt_zero;
            ctrl.alu      = shamt_zero ? ALU_SUB : ALU_ADD;
            ctrl.illegal  = !shamt_zero;
          end
          FN_SLT: begin
            ctrl.wants_wr = shamt_zero;
            ctrl.alu      = shamt_zero ? ALU_SLT : ALU_ADD;
            ctrl.illegal  = !shamt_zero;
          end
          FN_JRG:  ctrl.jreg    = 1'b1;
          default: ctrl.illegal = 1'b1;
        endcase
      end
      OPC_ADDI: begin
        ctrl.wants_wr = 1'b1;
        ctrl.src_imm  = 1'b1;
      end
      OPC_ORI: begin
        ctrl.wants_wr = 1'b1;
        ctrl.src_imm  = 1'b1;
        ctrl.alu      = ALU_OR;
        ctrl.ext      = EXT_ZERO;
      end
      OPC_LUI: begin
        ctrl.wants_wr = 1'b1;
        ctrl.src_imm  = 1'b1;
        ctrl.alu      = ALU_PASSB;
        ctrl.ext      = EXT_UPPER;
      end
      OPC_LDW: begin
        ctrl.wants_wr = 1'b1;
        ctrl.src_imm  = 1'b1;
        ctrl.mrd      = 1'b1;
      end
      OPC_STW: begin
        ctrl.src_imm  = 1'b1;
        ctrl.mwr      = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.br       = 1'b1;
        ctrl.alu      = ALU_SUB;
      end
      OPC_BNE: begin
        ctrl.br       = 1'b1;
        ctrl.br_ne    = 1'b1;
        ctrl.alu      = ALU_SUB;
      end
      OPC_JMP:  ctrl.jmp = 1'b1;
      OPC_JLINK: begin
        ctrl.jmp      = 1'b1;
        ctrl.link     = 1'b1;
        ctrl.wants_wr = 1'b1;
        ctrl.dst      = DST_LINK;
      end
      default: ctrl.illegal = 1'b1;
    endcase
  end

  always_comb begin
    if (!$isunknown({op, funct, shamt})) begin
      AST_ONE_EFFECT: assert ($countones({ctrl.mrd, ctrl.mwr, ctrl.br, ctrl.jmp, ctrl.jreg}) <= 1)
        else $error("more than one side-effect flag active"); // R11
      AST_ILLEGAL_QUIET: assert (!ctrl.illegal || (!ctrl.wants_wr && !ctrl.mwr && !ctrl.mrd && !ctrl.br && !ctrl.jmp && !ctrl.jreg))
        else $error("illegal word still has side effects"); // R10
      AST_LINK_JUMPS: assert (!ctrl.link || (ctrl.jmp && ctrl.wants_wr && ctrl.dst == DST_LINK))
        else $error("link without jump and write to link register"); // R7
    end
  end
endmodule

// File: rtl/mdec_immext.sv
module mdec_immext
  import mdec_pkg::*;
(
  input  logic [IMM_W-1:0] imm_i,
  input  ext_e             mode,
  output logic [XLEN-1:0]  imm_o
);
  localparam int PAD_W = XLEN - IMM_W;

  always_comb begin
    unique case (mode)
      EXT_ZERO:  imm_o = {{PAD_W{1'b0}}, imm_i};
      EXT_UPPER: imm_o = {imm_i, {PAD_W{1'b0}}};
      default:   imm_o = {{PAD_W{imm_i[IMM_W-1]}}, imm_i};
    endcase
  end

  always_comb begin
    if (!$isunknown({imm_i, mode})) begin
      AST_SIGN_VALUE: assert (mode != EXT_SIGN || $signed(imm_o) == XLEN'($signed(imm_i)))
        else $error("sign extension changed the value"); // R4
      AST_ZERO_VALUE: assert (mode != EXT_ZERO || imm_o == XLEN'(imm_i))
        else $error("zero extension changed the value"); // R4
      AST_UPPER_LOW_CLEAR: assert (mode != EXT_UPPER || (imm_o[IMM_W-1:0] == '0 && imm_o[XLEN-1 -: IMM_W] == imm_i))
        else $error("upper placement wrong"); // R4
    end
  end
endmodule

// File: rtl/mdec_wsel.sv
module mdec_wsel
  import mdec_pkg::*;
(
  input  logic [RIDX_W-1:0] rd,
  input  logic [RIDX_W-1:0] rt,
  input  dst_e              dst,
  input  logic              wants_wr,
  output logic [RIDX_W-1:0] wr_idx,
  output logic              we
);
  localparam logic [RIDX_W-1:0] LINK_R = RIDX_W'(LINK_IDX);

  always_comb begin
    unique case (dst)
      DST_RD:   wr_idx = rd;
      DST_LINK: wr_idx = LINK_R;
      default:  wr_idx = rt;
    endcase
  end

  assign we = wants_wr && (wr_idx != '0);

  always_comb begin
    if (!$isunknown({rd, rt, dst, wants_wr})) begin
      AST_NO_ZERO_WRITE: assert (!we || wr_idx != '0)
        else $error("write enabled toward register zero"); // R9
      AST_WRITE_NEEDS_REQ: assert (!we || wants_wr)
        else $error("write enabled without request"); // R9
    end
  end
endmodule

// File: rtl/mdec_top.sv
module mdec_top
  import mdec_pkg::*;
(
  input  logic [31:0] instr_i,
  output logic [4:0]  rs_idx_o,
  output logic [4:0]  rt_idx_o,
  output logic [4:0]  wr_idx_o,
  output logic        reg_we_o,
  output logic [2:0]  alu_op_o,
  output logic        alu_src_imm_o,
  output logic [1:0]  ext_mode_o,
  output logic [31:0] imm_o,
  output logic        mem_rd_o,
  output logic        mem_wr_o,
  output logic        branch_o,
  output logic        branch_ne_o,
  output logic        jump_o,
  output logic        jump_reg_o,
  output logic        link_o,
  output logic [25:0] jtarget_o,
  output logic        illegal_o
);
  logic [OP_W-1:0]   op;
  logic [RIDX_W-1:0] rd;
  logic [SH_W-1:0]   shamt;
  logic [FN_W-1:0]   funct;
  logic [IMM_W-1:0]  imm16;
  ctrl_t             ctrl;

  mdec_fields u_fields (
    .instr (instr_i),
    .op    (op),
    .rs    (rs_idx_o),
    .rt    (rt_idx_o),
    .rd    (rd),
    .shamt (shamt),
    .funct (funct),
    .imm   (imm16),
    .jt    (jtarget_o)
  );

  mdec_ctrl u_ctrl (
    .op    (op),
    .funct (funct),
    .shamt (shamt),
    .ctrl  (ctrl)
  );

  mdec_immext u_immext (
    .imm_i (imm16),
    .mode  (ctrl.ext),
    .imm_o (imm_o)
  );

  mdec_wsel u_wsel (
    .rd       (rd),
    .rt       (rt_idx_o),
    .dst      (ctrl.dst),
    .wants_wr (ctrl.wants_wr),
    .wr_idx   (wr_idx_o),
    .we       (reg_we_o)
  );

  assign alu_op_o      = ctrl.alu;
  assign alu_src_imm_o = ctrl.src_imm;
  assign ext_mode_o    = ctrl.ext;
  assign mem_rd_o      = ctrl.mrd;
  assign mem_wr_o      = ctrl.mwr;
  assign branch_o      = ctrl.br;
  assign branch_ne_o   = ctrl.br_ne;
  assign jump_o        = ctrl.jmp;
  assign jump_reg_o    = ctrl.jreg;
  assign link_o        = ctrl.link;
  assign illegal_o     = ctrl.illegal;

  always_comb begin
    if (!$isunknown(instr_i)) begin
      AST_BNE_IS_BRANCH: assert (!branch_ne_o || branch_o)
        else $error("inequality flag without branch"); // R6
      AST_STORE_NO_WRITE: assert (!mem_wr_o || !reg_we_o)
        else $error("store also writes a register"); // R5
      AST_IMM_OPERAND: assert (!(mem_rd_o || mem_wr_o) || alu_src_imm_o)
        else $error("memory access without immediate operand"); // R5
    end
  end
endmodule

// File: tb/tb_mdec_top.sv
module tb_mdec_top;
  localparam int CLK_PERIOD = 10;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic [31:0] instr = 32'h0;
  logic [4:0]  rs_idx, rt_idx, wr_idx;
  logic        reg_we, alu_src_imm, mem_rd, mem_wr, branch, branch_ne, jump, jump_reg, link, illegal;
  logic [2:0]  alu_op;
  logic [1:0]  ext_mode;
  logic [31:0] imm;
  logic [25:0] jtarget;

  mdec_top dut (
    .instr_i(instr), .rs_idx_o(rs_idx), .rt_idx_o(rt_idx), .wr_idx_o(wr_idx),
    .reg_we_o(reg_we), .alu_op_o(alu_op), .alu_src_imm_o(alu_src_imm),
    .ext_mode_o(ext_mode), .imm_o(imm), .mem_rd_o(mem_rd), .mem_wr_o(mem_wr),
    .branch_o(branch), .branch_ne_o(branch_ne), .jump_o(jump), .jump_reg_o(jump_reg),
    .link_o(link), .jtarget_o(jtarget), .illegal_o(illegal)
  );

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 0;

  int e_we, e_wr, e_alu, e_src, e_ext, e_mrd, e_mwr, e_br, e_bne, e_jmp, e_jreg, e_link, e_ill;
  longint e_imm;

  task automatic check(string tag, longint act, longint exp);
    n_checks++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s instr=%08h actual=%0h expected=%0h", tag, instr, act, exp);
    end
  endtask

  task automatic model(input logic [31:0] w);
    int op, fn, sh, rt, rd, i16;
    op = int'(w[31:26]); fn = int'(w[5:0]); sh = int'(w[10:6]);
    rt = int'(w[20:16]); rd = int'(w[15:11]); i16 = int'(w[15:0]);
    e_we = 0; e_alu = 0; e_src = 0; e_ext = 0; e_mrd = 0; e_mwr = 0;
    e_br = 0; e_bne = 0; e_jmp = 0; e_jreg = 0; e_link = 0; e_ill = 0;
    e_wr = (op == 0) ? rd : rt;
    if (op == 0) begin
      if (fn == 8) e_jreg = 1;
      else if ((fn == 32 || fn == 34 || fn == 42) && sh == 0) begin
        e_we = 1;
        e_alu = (fn == 32) ? 0 : (fn == 34) ? 1 : 2;
      end else e_ill = 1;
    end else begin
      case (op)
        8:  begin e_we = 1; e_src = 1; end
        13: begin e_we = 1; e_src = 1; e_alu = 3; e_ext = 1; end
        15: begin e_we = 1; e_src = 1; e_alu = 4; e_ext = 2; end
        35: begin e_we = 1; e_src = 1; e_mrd = 1; end
        43: begin e_src = 1; e_mwr = 1; end
        4:  begin e_br = 1; e_alu = 1; end
        5:  begin e_br = 1; e_bne = 1; e_alu = 1; end
        2:  e_jmp = 1;
        3:  begin e_jmp = 1; e_link = 1; e_we = 1; e_wr = 31; end
        default: e_ill = 1;
      endcase
    end
    if (e_wr == 0) e_we = 0;
    if (e_ext == 1)      e_imm = longint'(i16);
    else if (e_ext == 2) e_imm = longint'(i16) * 65536;
    else                 e_imm = (i16 >= 32768) ? longint'(i16) + 64'hFFFF0000 : longint'(i16);
  endtask

  task automatic apply(input logic [31:0] w);
    @(posedge clk);
    instr = w;
    model(w);
    @(negedge clk);
    check("R1 rs",        rs_idx, w[25:21]);
    check("R1 rt",        rt_idx, w[20:16]);
    check("R1 jtarget",   jtarget, w[25:0]);
    check("R9 wr_idx",    wr_idx, e_wr);
    check("R9 reg_we",    reg_we, e_we);
    check("R2 alu_op",    alu_op, e_alu);
    check("R3 src_imm",   alu_src_imm, e_src);
    check("R4 ext_mode",  ext_mode, e_ext);
    check("R4 imm",       imm, e_imm);
    check("R5 mem_rd",    mem_rd, e_mrd);
    check("R5 mem_wr",    mem_wr, e_mwr);
    check("R6 branch",    branch, e_br);
    check("R6 branch_ne", branch_ne, e_bne);
    check("R7 jump",      jump, e_jmp);
    check("R7 link",      link, e_link);
    check("R8 jump_reg",  jump_reg, e_jreg);
    check("R10 illegal",  illegal, e_ill);
    check("R11 exclusive", ($countones({mem_rd, mem_wr, branch, jump, jump_reg}) <= 1), 1);
  endtask

  function automatic logic [31:0] rtype(int rs, int rt, int rd, int sh, int fn);
    return {6'd0, 5'(rs), 5'(rt), 5'(rd), 5'(sh), 6'(fn)};
  endfunction
  function automatic logic [31:0] itype(int op, int rs, int rt, int im);
    return {6'(op), 5'(rs), 5'(rt), 16'(im)};
  endfunction

  initial begin
    #(CLK_PERIOD * 200000);
    if (!done) begin
      n_checks++; n_fail++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
      $finish;
    end
  end

  localparam int LEGAL_OPS [10] = '{0, 2, 3, 4, 5, 8, 13, 15, 35, 43};

  initial begin
    repeat (2) @(posedge clk);
    rst = 1'b0;
    @(negedge clk);
    model(32'h0);
    check("R10 reset word illegal", illegal, 1);
    check("R9 reset word no write", reg_we, 0);
    // R2 register arithmetic
    apply(rtype(1, 2, 3, 0, 32));
    apply(rtype(4, 5, 6, 0, 34));
    apply(rtype(7, 8, 9, 0, 42));
    apply(rtype(1, 2, 0, 0, 32));   // R9 destination zero
    // R3 and R4 immediate forms
    apply(itype(8, 29, 29, 16'hFFFC));
    apply(itype(8, 1, 0, 16'h0005)); // R9
    apply(itype(13, 3, 4, 16'h8000));
    apply(itype(15, 0, 16, 16'h003D));
    apply(itype(15, 0, 17, 16'hFFFF));
    // R5 memory
    apply(itype(35, 19, 8, 16'h0020));
    apply(itype(35, 19, 8, 16'hFFE0));
    apply(itype(43, 19, 8, 16'h0030));
    // R6 branches
    apply(itype(4, 17, 18, 16'h0019));
    apply(itype(5, 17, 18, 16'hFFF0));
    // R7 jumps
    apply({6'd2, 26'd2500});
    apply({6'd3, 26'h3FFFFFF});
    // R8 register jump with junk in other fields
    apply(rtype(31, 0, 0, 0, 8));
    apply(rtype(31, 7, 9, 3, 8));
    // R10 illegal cases
    apply(rtype(1, 2, 3, 4, 32));
    apply(rtype(1, 2, 3, 0, 33));
    apply(itype(63, 1, 2, 16'h1234));
    apply(itype(9, 1, 2, 16'h1234));
    for (int k = 0; k < 400; k++) begin
      logic [31:0] w;
      w = $urandom;
      if (k % 2 == 0) w[31:26] = 6'(LEGAL_OPS[$urandom % 10]);
      if (k % 4 == 0) begin
        w[31:26] = 6'd0;
        w[10:6] = ($urandom % 3 == 0) ? 5'(w[10:6]) : 5'd0;
        case ($urandom % 5)
          0: w[5:0] = 6'd32;
          1: w[5:0] = 6'd34;
          2: w[5:0] = 6'd42;
          3: w[5:0] = 6'd8;
          default: ;
        endcase
      end
      apply(w);
    end
    done = 1;
    $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
    $finish;
  end
endmodule